// File: doc/BRIEF.md
# Page Execute Permission Checker

This block decides whether one access to a translated page may go ahead. It looks at the 64-bit paging-structure entries collected by a table walk, at most four levels of them. A per-level mask says which of those entries actually mapped the page. From the entries, the access kind (read, write or instruction fetch), the privilege of the requester and the paging mode, it produces a permit flag, a fault flag and a two-bit fault reason. All of this is combinational.

A small extended-feature control register sits next to the checker. It holds a syscall-enable bit, a long-mode-enable bit, a long-mode-active status bit and the global no-execute enable. Software writes the register through a one-cycle write port. The port refuses any write that would set a reserved bit. It also refuses a write that turns on no-execute while the capability input is low. A refused write raises a general-protection flag in the same cycle and leaves the register as it was. The register's no-execute bit gates the execute-disable check.

The no-execute check is the OR of bit 63 over every used level. It applies only to instruction fetches, and only in the two 64-bit entry formats. The usual user/supervisor and read/write checks run beside it on their own.

Top module: `page_exec_check`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ctl_o` reads all zeros and `wr_gp_o` is 0 when no write is presented.
- R2: The outcome is fault with reason 1 (no-execute) when all of the following hold: `acc_i` is 2'b10 (fetch), `ctl_o[11]` is 1, `mode_i` is not 2'b00, and bit 63 is 1 in any entry whose `lvl_use_i` bit is 1. This holds whatever the other levels hold.
- R3: No no-execute fault occurs when `ctl_o[11]` is 0. None occurs either when every entry with bit 63 set has its `lvl_use_i` bit at 0.
- R4: When `mode_i` is 2'b00 (legacy 32-bit paging), bit 63 is never sampled, so reason 1 never appears.
- R5: Access codes 2'b00 (read), 2'b01 (write) and 2'b11 (treated as read) never produce reason 1.
- R6: A user access (`user_i`=1) faults with reason 2 (privilege) when any used entry has bit 2 (user-allowed) at 0.
- R7: A write access (`acc_i`=2'b01) faults with reason 3 (write-protect) when any used entry has bit 1 (writable) at 0, at either privilege level.
- R8: When several violations are present, no-execute beats privilege, and privilege beats write-protect. `permit_o` is 1 exactly when the reason is 0, and `fault_o` is its inverse.
- R9: A write with bit 11 set while `nx_cap_i` is 0 raises `wr_gp_o` in the same cycle and leaves `ctl_o` unchanged after the edge.
- R10: A write with any bit other than 0, 8, 10 or 11 set raises `wr_gp_o` and leaves `ctl_o` unchanged after the edge.
- R11: An accepted write loads bits 0, 8 and 11 on the clock edge. Bit 10 ignores the write data and takes the value of `lma_i` at every edge out of reset.
- R12: `wr_gp_o` is 0 whenever `wr_en_i` is 0, and `ctl_o` then changes only in bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_i | input | LEVELS*ENTRY_W | Walk entries; level k occupies bits k*ENTRY_W upward |
| lvl_use_i | input | LEVELS | One bit per level: entry took part in the mapping |
| acc_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| user_i | input | 1 | 1 for a user-privilege access |
| mode_i | input | 2 | Paging mode: 00 legacy 32-bit, 01 PAE-style, 10/11 long mode |
| nx_cap_i | input | 1 | No-execute capability present |
| lma_i | input | 1 | Long-mode-active status, copied into bit 10 |
| wr_en_i | input | 1 | Software write strobe for the control register |
| wr_data_i | input | CTL_W | Software write data |
| ctl_o | output | CTL_W | Current control register value |
| wr_gp_o | output | 1 | Presented write is illegal (general-protection) |
| permit_o | output | 1 | Access allowed |
| fault_o | output | 1 | Access refused (page-fault condition) |
| reason_o | output | 2 | 0 none, 1 no-execute, 2 privilege, 3 write-protect |

## Verification
The assertions assume that access and mode codes, entries and the level mask only change between clock edges. They also assume that `lma_i` is a clean level, because bit 10 is compared with its value one edge earlier. The bench meets these assumptions by driving every input on the falling edge and holding it through the next rising edge. It samples combinational outputs a short delay after it drives them, and register contents only after the falling edge that follows an update. The checker is combinational, so the assertions on reason codes relate port values within a single cycle. Only the register rules look one edge back, and those assertions are disabled while reset is low.

// File: rtl/pxc_pkg.sv
`timescale 1ns/1ps
package pxc_pkg;

  // Entry bit positions decoded by the checker
  localparam int XD_BIT = 63;
  localparam int US_BIT = 2;
  localparam int RW_BIT = 1;

  // Control register bit positions (software-visible layout)
  localparam int CTL_SCE = 0;
  localparam int CTL_LME = 8;
  localparam int CTL_LMA = 10;
  localparam int CTL_NXE = 11;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    PG_LEGACY32 = 2'b00,
    PG_PAE      = 2'b01,
    PG_LONG     = 2'b10,
    PG_LONG_ALT = 2'b11
  } pgmode_e;

  typedef enum logic [1:0] {
    RSN_NONE   = 2'd0,
    RSN_NOEXEC = 2'd1,
    RSN_PRIV   = 2'd2,
    RSN_WPROT  = 2'd3
  } reason_e;

  // Entries carry bit 63 only in the 64-bit formats
  function automatic logic wide_entries(input logic [1:0] mode);
    return mode != PG_LEGACY32;
  endfunction

  function automatic logic is_fetch(input logic [1:0] acc);
    return acc == ACC_FETCH;
  endfunction

  function automatic logic is_write(input logic [1:0] acc);
    return acc == ACC_WRITE;
  endfunction

  // Fixed priority: no-execute, then privilege, then write-protect
  function automatic logic [1:0] pick_reason(input logic nx, input logic priv,
                                             input logic wp);
    if (nx)        return RSN_NOEXEC;
    else if (priv) return RSN_PRIV;
    else if (wp)   return RSN_WPROT;
    else           return RSN_NONE;
  endfunction

endpackage

// File: rtl/pxc_ctl_reg.sv
`timescale 1ns/1ps
module pxc_ctl_reg
  import pxc_pkg::*;
#(
  parameter int CTL_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             nx_cap,
  input  logic             lma,
  output logic [CTL_W-1:0] ctl_q,
  output logic             gp,
  output logic             nxe
);

  localparam logic [CTL_W-1:0] ONE       = CTL_W'(1);
  localparam logic [CTL_W-1:0] SW_MASK   = (ONE << CTL_SCE) | (ONE << CTL_LME) |
                                           (ONE << CTL_NXE);
  localparam logic [CTL_W-1:0] STAT_MASK = ONE << CTL_LMA;
  localparam logic [CTL_W-1:0] RESV_MASK = ~(SW_MASK | STAT_MASK);

  // Named write-filter events
  logic             resv_hit;
  logic             nx_bad;
  logic             accept;
  logic [CTL_W-1:0] ctl_d;

  assign resv_hit = |(wr_data & RESV_MASK);
  assign nx_bad   = wr_data[CTL_NXE] & ~nx_cap;
  assign gp       = wr_en & (resv_hit | nx_bad);
  assign accept   = wr_en & ~(resv_hit | nx_bad);

  always_comb begin
    ctl_d = ctl_q;
    if (accept) begin
      ctl_d = (ctl_q & ~SW_MASK) | (wr_data & SW_MASK);
    end
    ctl_d[CTL_LMA] = lma;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign nxe = ctl_q[CTL_NXE];

  // R9 / R10: a refused write leaves the software bits untouched
  assert_reject_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gp |=> $stable(ctl_q & SW_MASK));

  // R10: reserved bits never become visible
  assert_resv_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & RESV_MASK) == '0);

  // R11: status bit follows the input one edge later
  assert_lma_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ctl_q[CTL_LMA] == $past(lma));

  // R12: no strobe, no fault, no change to software bits
  assert_gp_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !gp);
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q & SW_MASK));

endmodule

// File: rtl/pxc_nx_scan.sv
`timescale 1ns/1ps
module pxc_nx_scan
  import pxc_pkg::*;
#(
  parameter int LEVELS  = 4,
  parameter int ENTRY_W = 64
) (
  input  logic [LEVELS*ENTRY_W-1:0] ent,
  input  logic [LEVELS-1:0]         lvl_use,
  input  logic [1:0]                mode,
  input  logic [1:0]                acc,
  input  logic                      nxe,
  output logic                      xd_any,
  output logic                      nx_block
);

  logic [LEVELS-1:0] xd_lvl;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign xd_lvl[g] = lvl_use[g] & ent[g*ENTRY_W + XD_BIT];
  end

  // OR over all used levels; one set flag is enough
  assign xd_any   = |xd_lvl;
  assign nx_block = nxe & wide_entries(mode) & is_fetch(acc) & xd_any;

endmodule

// File: rtl/pxc_priv_scan.sv
`timescale 1ns/1ps
module pxc_priv_scan
  import pxc_pkg::*;
#(
  parameter int LEVELS  = 4,
  parameter int ENTRY_W = 64
) (
  input  logic [LEVELS*ENTRY_W-1:0] ent,
  input  logic [LEVELS-1:0]         lvl_use,
  input  logic [1:0]                acc,
  input  logic                      user,
  output logic                      priv_block,
  output logic                      wp_block
);

  logic [LEVELS-1:0] us_deny;
  logic [LEVELS-1:0] rw_deny;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign us_deny[g] = lvl_use[g] & ~ent[g*ENTRY_W + US_BIT];
    assign rw_deny[g] = lvl_use[g] & ~ent[g*ENTRY_W + RW_BIT];
  end

  assign priv_block = user & (|us_deny);
  assign wp_block   = is_write(acc) & (|rw_deny);

endmodule

// File: rtl/page_exec_check.sv
`timescale 1ns/1ps
module page_exec_check
  import pxc_pkg::*;
#(
  parameter int LEVELS  = 4,
  parameter int ENTRY_W = 64,
  parameter int CTL_W   = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LEVELS*ENTRY_W-1:0] ent_i,
  input  logic [LEVELS-1:0]         lvl_use_i,
  input  logic [1:0]                acc_i,
  input  logic                      user_i,
  input  logic [1:0]                mode_i,
  input  logic                      nx_cap_i,
  input  logic                      lma_i,
  input  logic                      wr_en_i,
  input  logic [CTL_W-1:0]          wr_data_i,
  output logic [CTL_W-1:0]          ctl_o,
  output logic                      wr_gp_o,
  output logic                      permit_o,
  output logic                      fault_o,
  output logic [1:0]                reason_o
);

  // Internal events brought out for the assertions
  logic nxe;
  logic xd_any;
  logic nx_block;
  logic priv_block;
  logic wp_block;

  pxc_ctl_reg #(.CTL_W(CTL_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .nx_cap  (nx_cap_i),
    .lma     (lma_i),
    .ctl_q   (ctl_o),
    .gp      (wr_gp_o),
    .nxe     (nxe)
  );

  pxc_nx_scan #(.LEVELS(LEVELS), .ENTRY_W(ENTRY_W)) u_nx (
    .ent      (ent_i),
    .lvl_use  (lvl_use_i),
    .mode     (mode_i),
    .acc      (acc_i),
    .nxe      (nxe),
    .xd_any   (xd_any),
    .nx_block (nx_block)
  );

  pxc_priv_scan #(.LEVELS(LEVELS), .ENTRY_W(ENTRY_W)) u_priv (
    .ent        (ent_i),
    .lvl_use    (lvl_use_i),
    .acc        (acc_i),
    .user       (user_i),
    .priv_block (priv_block),
    .wp_block   (wp_block)
  );

  assign reason_o = pick_reason(nx_block, priv_block, wp_block);
  assign permit_o = (reason_o == RSN_NONE);
  assign fault_o  = ~permit_o;

  // R2: enable, wide format, fetch and a used flag together force reason 1
  assert_nx_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o[CTL_NXE] && mode_i != PG_LEGACY32 && acc_i == ACC_FETCH && xd_any)
      |-> (reason_o == RSN_NOEXEC && fault_o));

  // R3: a cleared enable never yields reason 1
  assert_nxe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_o[CTL_NXE] |-> reason_o != RSN_NOEXEC);

  // R4: legacy paging never yields reason 1
  assert_legacy_no_nx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PG_LEGACY32) |-> reason_o != RSN_NOEXEC);

  // R5: data accesses never yield reason 1
  assert_data_no_nx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i != ACC_FETCH) |-> reason_o != RSN_NOEXEC);

  // R8: privilege outranks write-protect
  assert_priv_over_wp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_block && !nx_block) |-> reason_o == RSN_PRIV);

endmodule

// File: tb/test_page_exec_check.sv
`timescale 1ns/1ps
module test_page_exec_check;

  localparam int LEVELS  = 4;
  localparam int ENTRY_W = 64;
  localparam int CTL_W   = 64;
  localparam int NROWS   = 13;

  // Row: {nxe, mode[1:0], acc[1:0], user, use[3:0], xd[3:0], us[3:0], rw[3:0], exp[1:0]}
  localparam logic [23:0] VEC [NROWS] = '{
    {1'b1, 2'd2, 2'd2, 1'b0, 4'hF, 4'h4, 4'hF, 4'hF, 2'd1}, // R2 one middle level
    {1'b0, 2'd2, 2'd2, 1'b0, 4'hF, 4'h4, 4'hF, 4'hF, 2'd0}, // R3 enable off
    {1'b1, 2'd0, 2'd2, 1'b0, 4'h3, 4'hF, 4'hF, 4'hF, 2'd0}, // R4 legacy
    {1'b1, 2'd2, 2'd0, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 2'd0}, // R5 read
    {1'b1, 2'd2, 2'd1, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 2'd0}, // R5 write
    {1'b1, 2'd1, 2'd2, 1'b0, 4'h7, 4'h8, 4'hF, 4'hF, 2'd0}, // R3 flag on unused level
    {1'b1, 2'd2, 2'd0, 1'b1, 4'hF, 4'h0, 4'hE, 4'hF, 2'd2}, // R6 user denied
    {1'b1, 2'd2, 2'd1, 1'b0, 4'hF, 4'h0, 4'h0, 4'hB, 2'd3}, // R7 supervisor write
    {1'b1, 2'd2, 2'd2, 1'b1, 4'hF, 4'h1, 4'h0, 4'hF, 2'd1}, // R8 nx beats priv
    {1'b1, 2'd2, 2'd1, 1'b1, 4'hF, 4'h0, 4'hD, 4'h7, 2'd2}, // R8 priv beats wp
    {1'b1, 2'd3, 2'd3, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 2'd0}, // R5 alt code is read
    {1'b1, 2'd0, 2'd1, 1'b1, 4'h3, 4'h0, 4'hF, 4'hE, 2'd3}, // R7 legacy write
    {1'b1, 2'd1, 2'd2, 1'b1, 4'h7, 4'h2, 4'hF, 4'hF, 2'd1}  // R2 PAE format
  };

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic [LEVELS*ENTRY_W-1:0] ent_i;
  logic [LEVELS-1:0]         lvl_use_i;
  logic [1:0]                acc_i;
  logic                      user_i;
  logic [1:0]                mode_i;
  logic                      nx_cap_i;
  logic                      lma_i;
  logic                      wr_en_i;
  logic [CTL_W-1:0]          wr_data_i;
  logic [CTL_W-1:0]          ctl_o;
  logic                      wr_gp_o;
  logic                      permit_o;
  logic                      fault_o;
  logic [1:0]                reason_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;
  logic seen_gp;

  always #10 clk = ~clk;

  page_exec_check #(.LEVELS(LEVELS), .ENTRY_W(ENTRY_W), .CTL_W(CTL_W)) i_page_exec_check (
    .clk(clk), .rst_n(rst_n), .ent_i(ent_i), .lvl_use_i(lvl_use_i), .acc_i(acc_i),
    .user_i(user_i), .mode_i(mode_i), .nx_cap_i(nx_cap_i), .lma_i(lma_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .ctl_o(ctl_o), .wr_gp_o(wr_gp_o),
    .permit_o(permit_o), .fault_o(fault_o), .reason_o(reason_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h, expected 0x%0h", req, act, exp);
    end
  endtask

  // One write cycle: drive on the falling edge, capture gp, release after the edge
  task automatic sw_write(input logic [63:0] d, input logic cap);
    @(negedge clk);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    nx_cap_i  = cap;
    #2 seen_gp = wr_gp_o;
    @(negedge clk);
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ent_i = '0; lvl_use_i = '0; acc_i = 2'b00; user_i = 1'b0;
    mode_i = 2'b10; nx_cap_i = 1'b1; lma_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    check("R1 ctl in reset", ctl_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctl after reset", ctl_o, 64'h0);
    check("R1 gp idle", {63'b0, wr_gp_o}, 64'h0);

    // Table walk
    for (int r = 0; r < NROWS; r++) begin
      logic [23:0] v;
      logic [1:0]  ex;
      v  = VEC[r];
      ex = v[1:0];
      sw_write(v[23] ? 64'h800 : 64'h0, 1'b1);
      mode_i    = v[22:21];
      acc_i     = v[20:19];
      user_i    = v[18];
      lvl_use_i = v[17:14];
      for (int k = 0; k < LEVELS; k++) begin
        logic [63:0] e;
        e = 64'h0000_0000_0012_3001;
        e[63] = v[10 + k];
        e[2]  = v[6 + k];
        e[1]  = v[2 + k];
        ent_i[k*ENTRY_W +: ENTRY_W] = e;
      end
      #2;
      case (r)
        0, 12:     check("R2 reason", {62'b0, reason_o}, {62'b0, ex});
        1, 5:      check("R3 reason", {62'b0, reason_o}, {62'b0, ex});
        2:         check("R4 reason", {62'b0, reason_o}, {62'b0, ex});
        3, 4, 10:  check("R5 reason", {62'b0, reason_o}, {62'b0, ex});
        6:         check("R6 reason", {62'b0, reason_o}, {62'b0, ex});
        7, 11:     check("R7 reason", {62'b0, reason_o}, {62'b0, ex});
        default:   check("R8 reason", {62'b0, reason_o}, {62'b0, ex});
      endcase
      check("R8 permit", {63'b0, permit_o}, {63'b0, ex == 2'd0});
      check("R8 fault",  {63'b0, fault_o},  {63'b0, ex != 2'd0});
    end

    // R11: status bit tracks lma_i, software bits load on an accepted write
    sw_write(64'h0, 1'b1);
    lma_i = 1'b1;
    @(negedge clk);
    check("R11 lma copied", ctl_o, 64'h400);
    sw_write(64'h101, 1'b1);
    check("R11 legal write no gp", {63'b0, seen_gp}, 64'h0);
    check("R11 legal write value", ctl_o, 64'h501);
    lma_i = 1'b0;
    sw_write(64'h401, 1'b1);
    check("R11 bit10 ignores data", ctl_o, 64'h001);

    // R9: enable without capability
    sw_write(64'h801, 1'b0);
    check("R9 gp raised", {63'b0, seen_gp}, 64'h1);
    check("R9 value kept", ctl_o, 64'h001);

    // R10: reserved bits
    sw_write(64'h1000_0000_0000_0001, 1'b1);
    check("R10 gp high reserved", {63'b0, seen_gp}, 64'h1);
    check("R10 value kept", ctl_o, 64'h001);
    sw_write(64'h201, 1'b1);
    check("R10 gp bit9", {63'b0, seen_gp}, 64'h1);
    check("R10 value kept bit9", ctl_o, 64'h001);

    // R12: data without strobe
    @(negedge clk);
    wr_data_i = '1;
    nx_cap_i  = 1'b0;
    #2 check("R12 gp quiet", {63'b0, wr_gp_o}, 64'h0);
    @(negedge clk);
    check("R12 value kept", ctl_o, 64'h001);
    wr_data_i = '0;

    // R9 converse: with capability the enable is accepted
    sw_write(64'h800, 1'b1);
    check("R9 enable accepted gp", {63'b0, seen_gp}, 64'h0);
    check("R9 enable accepted value", ctl_o, 64'h800);

    // R1: reset mid-run clears the register
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", ctl_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule